// File: doc/BRIEF.md
# Pipeline Bypass and Stall Unit

This block is the purely combinational hazard controller of a five-stage in-order scalar pipeline (fetch, decode, execute, memory, writeback). A four-stage pipelined multiplier sits beside the execute stage and returns its results through writeback. Every cycle the unit looks at the register fields, operation class and valid bits of the instructions held in decode, execute, memory, writeback and the multiplier stages. From these it picks the operand source for each of the two ALU inputs, decides whether the store-data input of data memory takes the writeback value, and raises one stall line.

The stall line tells the surrounding pipeline to keep the PC and the decode latch unchanged and to put a bubble into execute. The conditions are checked again in the next cycle. The stall covers the load-to-use case and three multiplier cases: a read of a register that a multiply is still producing, two writes to the register file in the same cycle, and a younger write reaching a register before an older multiply does. Operation classes are encoded as 0 = ALU, 1 = load, 2 = store, 3 = multiply.

Top module: `fwd_stall_ctrl`

## Requirements
- R1: `sel_a` selects the source for the execute-stage first operand (`x_rs1`). It is 0 when a live memory-stage writer (`m_valid`, `m_we`, `m_rd` non-zero) has `m_rd == x_rs1`. Otherwise it is 1 when a live writeback writer has `w_rd == x_rs1`. Otherwise it is 2, meaning the register file. The memory stage wins when both stages match.
- R2: `sel_b` follows the same rule for `x_rs2` and does not depend on `x_rs1`.
- R3: `sel_st` is 1 only when the memory stage holds a valid store (`m_op` = 2) whose data register `m_rs2` is non-zero and equals the destination of a live writeback writer. In every other case it is 0. The writeback value reaches memory on this path only; the address is formed through the ALU selects.
- R4: The unit stalls when decode is valid and execute holds a valid load (`x_op` = 1) that writes a non-zero `x_rd` equal to `d_rs1`.
- R5: A match between `d_rs2` and such a load's `x_rd` stalls only when the decode instruction is not a store (`d_op` != 2).
- R6: The unit stalls when either decode source equals the non-zero destination of a valid entry in multiplier stages P0 to P(NMUL-2). With NMUL = 4 these are `p_valid` bits 0 to 2.
- R7: The unit stalls when decode writes a non-zero register, is not a multiply (`d_op` != 3), and multiplier stage P(NMUL-3) holds a valid non-zero destination. This stall prevents two register-file writes in one cycle.
- R8: The unit stalls when decode writes a non-zero register equal to the destination of a valid entry in P0. This stall keeps writes to one register in order.
- R9: Register 0 and destinations without their valid and write-enable bits never produce a bypass match or a stall.
- R10: `stall` is the OR of all stall conditions and is 0 whenever `d_valid` is 0. The selects are computed the same way whether or not a stall is raised.
- R11: When the multiplier advances one stage per cycle, a consumer of a multiply result waits exactly three cycles in decode. A non-multiply instruction that writes the multiply's destination and follows it directly waits exactly two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_valid | input | 1 | Decode stage holds an instruction |
| d_op | input | 2 | Decode operation class |
| d_rs1 | input | RW | Decode first source register |
| d_rs2 | input | RW | Decode second source register |
| d_rd | input | RW | Decode destination register |
| d_we | input | 1 | Decode instruction writes a register |
| x_valid | input | 1 | Execute stage holds an instruction |
| x_op | input | 2 | Execute operation class |
| x_rs1 | input | RW | Execute first source register |
| x_rs2 | input | RW | Execute second source register |
| x_rd | input | RW | Execute destination register |
| x_we | input | 1 | Execute instruction writes a register |
| m_valid | input | 1 | Memory stage holds an instruction |
| m_op | input | 2 | Memory operation class |
| m_rs2 | input | RW | Store-data register of the memory-stage instruction |
| m_rd | input | RW | Memory destination register |
| m_we | input | 1 | Memory instruction writes a register |
| w_valid | input | 1 | Writeback stage holds an instruction |
| w_rd | input | RW | Writeback destination register |
| w_we | input | 1 | Writeback instruction writes a register |
| p_valid | input | NMUL-1 | Valid bits of multiplier stages P0 to P(NMUL-2) |
| p_rd | input | (NMUL-1)*RW | Destinations of multiplier stages P0 to P(NMUL-2) |
| sel_a | output | 2 | First ALU operand source: 0 memory, 1 writeback, 2 register file |
| sel_b | output | 2 | Second ALU operand source, same encoding |
| sel_st | output | 1 | Store data taken from writeback |
| stall | output | 1 | Hold PC and decode, put a bubble into execute |

## Verification
The bench uses a 2-bit register index, so register 0 and register collisions come up often. It first runs directed patterns: both forwarding stages matching at once, which shows whether the memory stage has priority; a load followed by a store or by an ALU consumer, which shows whether the store exemption is applied; and multiplier entries placed in each tracked stage, which show the read, write-port and ordering stalls apart from each other. Two short sequences move a multiply through the multiplier stages and count how many cycles decode is held, which tells the three-cycle wait apart from the two-cycle wait. A long pseudo-random sweep then compares all four outputs against a model built from the requirements.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      OPC_ALU   = 2'd0,
      OPC_LOAD  = 2'd1,
      OPC_STORE = 2'd2,
      OPC_MUL   = 2'd3
   } opc_e;

   typedef enum logic [1:0] {
      SRC_MEM = 2'd0,
      SRC_WB  = 2'd1,
      SRC_RF  = 2'd2
   } fwd_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick #(
   parameter int RW = 5
) (
   input  logic [RW-1:0] src,
   input  logic          m_wr,
   input  logic [RW-1:0] m_rd,
   input  logic          w_wr,
   input  logic [RW-1:0] w_rd,
   output logic [1:0]    sel
);
   import hzd_pkg::*;

   logic live, hit_m, hit_w;

   always_comb begin
      live  = |src;
      hit_m = live && m_wr && (m_rd == src);
      hit_w = live && w_wr && (w_rd == src);
      if (hit_m)      sel = SRC_MEM;
      else if (hit_w) sel = SRC_WB;
      else            sel = SRC_RF;
   end

   // R9: a zero source always reads the register file
   always_comb begin
      if (src == '0) assert_zero_reads_rf_R9: assert (sel == SRC_RF);
   end
endmodule

// File: rtl/ld_use_det.sv
module ld_use_det #(
   parameter int RW = 5
) (
   input  logic          x_ld,
   input  logic [RW-1:0] x_rd,
   input  logic [RW-1:0] d_rs1,
   input  logic [RW-1:0] d_rs2,
   input  logic          d_is_store,
   output logic          hit
);
   logic hit1, hit2;

   assign hit1 = x_ld && (d_rs1 == x_rd);
   assign hit2 = x_ld && (d_rs2 == x_rd) && !d_is_store;
   assign hit  = hit1 || hit2;

   // R5: a store whose data register alone matches is not held
   always_comb begin
      if (x_ld && d_is_store && (d_rs1 != x_rd))
         assert_store_exempt_R5: assert (!hit);
   end
endmodule

// File: rtl/mul_hzd_det.sv
module mul_hzd_det #(
   parameter int RW   = 5,
   parameter int NMUL = 4
) (
   input  logic [NMUL-2:0]         p_valid,
   input  logic [NMUL-2:0][RW-1:0] p_rd,
   input  logic [RW-1:0]           d_rs1,
   input  logic [RW-1:0]           d_rs2,
   input  logic [RW-1:0]           d_rd,
   input  logic                    d_wr,
   input  logic                    d_is_mul,
   output logic                    raw_hit,
   output logic                    port_hit,
   output logic                    order_hit
);
   localparam int NTRK     = NMUL - 1;
   localparam int PORT_IDX = NMUL - 3;

   logic [NTRK-1:0] stage_live;
   logic [NTRK-1:0] stage_raw;

   for (genvar i = 0; i < NTRK; i++) begin : g_trk
      assign stage_live[i] = p_valid[i] && (|p_rd[i]);
      assign stage_raw[i]  = stage_live[i] &&
                             ((p_rd[i] == d_rs1) || (p_rd[i] == d_rs2));
   end

   assign raw_hit   = |stage_raw;
   assign port_hit  = d_wr && !d_is_mul && stage_live[PORT_IDX];
   assign order_hit = d_wr && stage_live[0] && (p_rd[0] == d_rd);

   // R6: the youngest multiply is always seen by a reader of its result
   always_comb begin
      if (p_valid[0] && (|p_rd[0]) && (p_rd[0] == d_rs1))
         assert_young_mul_raw_R6: assert (raw_hit);
   end

   // R7: a non-multiply writer never shares the port cycle with a multiply
   always_comb begin
      if (d_wr && !d_is_mul && p_valid[PORT_IDX] && (|p_rd[PORT_IDX]))
         assert_port_clash_R7: assert (port_hit);
   end
endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl #(
   parameter int RW   = 5,
   parameter int NMUL = 4
) (
   input  logic                    d_valid,
   input  logic [1:0]              d_op,
   input  logic [RW-1:0]           d_rs1,
   input  logic [RW-1:0]           d_rs2,
   input  logic [RW-1:0]           d_rd,
   input  logic                    d_we,
   input  logic                    x_valid,
   input  logic [1:0]              x_op,
   input  logic [RW-1:0]           x_rs1,
   input  logic [RW-1:0]           x_rs2,
   input  logic [RW-1:0]           x_rd,
   input  logic                    x_we,
   input  logic                    m_valid,
   input  logic [1:0]              m_op,
   input  logic [RW-1:0]           m_rs2,
   input  logic [RW-1:0]           m_rd,
   input  logic                    m_we,
   input  logic                    w_valid,
   input  logic [RW-1:0]           w_rd,
   input  logic                    w_we,
   input  logic [NMUL-2:0]         p_valid,
   input  logic [NMUL-2:0][RW-1:0] p_rd,
   output logic [1:0]              sel_a,
   output logic [1:0]              sel_b,
   output logic                    sel_st,
   output logic                    stall
);
   import hzd_pkg::*;

   if (NMUL < 3) begin : g_bad_nmul
      $error("fwd_stall_ctrl: NMUL must be at least 3");
   end
   if (RW < 1) begin : g_bad_rw
      $error("fwd_stall_ctrl: RW must be at least 1");
   end

   logic m_wr, w_wr, x_ld, d_wr;
   logic lu_hit, raw_hit, port_hit, order_hit;
   logic [1:0][RW-1:0] x_src;
   logic [1:0][1:0]    alu_sel;

   assign m_wr = m_valid && m_we && (|m_rd);
   assign w_wr = w_valid && w_we && (|w_rd);
   assign x_ld = x_valid && x_we && (|x_rd) && (x_op == OPC_LOAD);
   assign d_wr = d_we && (|d_rd);

   assign x_src = {x_rs2, x_rs1};

   for (genvar g = 0; g < 2; g++) begin : g_alu_in
      fwd_pick #(.RW(RW)) u_pick (
         .src  (x_src[g]),
         .m_wr (m_wr),
         .m_rd (m_rd),
         .w_wr (w_wr),
         .w_rd (w_rd),
         .sel  (alu_sel[g])
      );
   end

   assign sel_a  = alu_sel[0];
   assign sel_b  = alu_sel[1];
   assign sel_st = m_valid && (m_op == OPC_STORE) && (|m_rs2) &&
                   w_wr && (w_rd == m_rs2);

   ld_use_det #(.RW(RW)) u_ld_use (
      .x_ld       (x_ld),
      .x_rd       (x_rd),
      .d_rs1      (d_rs1),
      .d_rs2      (d_rs2),
      .d_is_store (d_op == OPC_STORE),
      .hit        (lu_hit)
   );

   mul_hzd_det #(.RW(RW), .NMUL(NMUL)) u_mul_hzd (
      .p_valid   (p_valid),
      .p_rd      (p_rd),
      .d_rs1     (d_rs1),
      .d_rs2     (d_rs2),
      .d_rd      (d_rd),
      .d_wr      (d_wr),
      .d_is_mul  (d_op == OPC_MUL),
      .raw_hit   (raw_hit),
      .port_hit  (port_hit),
      .order_hit (order_hit)
   );

   assign stall = d_valid && (lu_hit || raw_hit || port_hit || order_hit);

   // R1: a live memory-stage match on the first operand takes priority
   always_comb begin
      if ((|x_rs1) && m_valid && m_we && (m_rd == x_rs1))
         assert_mem_first_R1: assert (sel_a == SRC_MEM);
   end

   // R3: the writeback-to-memory path is used for stores only
   always_comb begin
      if (sel_st) assert_wb_store_only_R3: assert (m_valid && m_op == OPC_STORE);
   end

   // R10: an empty decode stage is never held
   always_comb begin
      if (!d_valid) assert_idle_no_stall_R10: assert (!stall);
   end

   // R4: a load feeding the first decode source always holds decode
   always_comb begin
      if (d_valid && x_valid && x_we && (x_op == OPC_LOAD) && (|x_rd) && (d_rs1 == x_rd))
         assert_load_use_R4: assert (stall);
   end
endmodule

// File: tb/test_fwd_stall_ctrl.sv
module test_fwd_stall_ctrl;
   localparam int RW   = 2;
   localparam int NMUL = 4;
   localparam int NT   = NMUL - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          d_valid, d_we, x_valid, x_we, m_valid, m_we, w_valid, w_we;
   logic [1:0]    d_op, x_op, m_op;
   logic [RW-1:0] d_rs1, d_rs2, d_rd, x_rs1, x_rs2, x_rd, m_rs2, m_rd, w_rd;
   logic [NT-1:0] p_valid;
   logic [NT-1:0][RW-1:0] p_rd;
   logic [1:0]    sel_a, sel_b;
   logic          sel_st, stall;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   fwd_stall_ctrl #(.RW(RW), .NMUL(NMUL)) i_fwd_stall_ctrl (
      .d_valid(d_valid), .d_op(d_op), .d_rs1(d_rs1), .d_rs2(d_rs2), .d_rd(d_rd), .d_we(d_we),
      .x_valid(x_valid), .x_op(x_op), .x_rs1(x_rs1), .x_rs2(x_rs2), .x_rd(x_rd), .x_we(x_we),
      .m_valid(m_valid), .m_op(m_op), .m_rs2(m_rs2), .m_rd(m_rd), .m_we(m_we),
      .w_valid(w_valid), .w_rd(w_rd), .w_we(w_we),
      .p_valid(p_valid), .p_rd(p_rd),
      .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st), .stall(stall)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      d_valid = 0; d_op = 0; d_rs1 = 0; d_rs2 = 0; d_rd = 0; d_we = 0;
      x_valid = 0; x_op = 0; x_rs1 = 0; x_rs2 = 0; x_rd = 0; x_we = 0;
      m_valid = 0; m_op = 0; m_rs2 = 0; m_rd = 0; m_we = 0;
      w_valid = 0; w_rd = 0; w_we = 0;
      p_valid = '0; p_rd = '0;
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   // reference model from the requirements
   function automatic int want_sel(input logic [RW-1:0] s);
      if (s != 0 && m_valid && m_we && m_rd != 0 && m_rd == s) return 0;
      if (s != 0 && w_valid && w_we && w_rd != 0 && w_rd == s) return 1;
      return 2;
   endfunction

   function automatic int want_st();
      return int'(m_valid && m_op == 2 && m_rs2 != 0 && w_valid && w_we &&
                  w_rd != 0 && w_rd == m_rs2);
   endfunction

   function automatic int want_stall();
      bit lu, raw, prt, ord;
      lu = x_valid && x_op == 1 && x_we && x_rd != 0 &&
           (d_rs1 == x_rd || (d_rs2 == x_rd && d_op != 2));
      raw = 0;
      for (int i = 0; i < NT; i++)
         if (p_valid[i] && p_rd[i] != 0 && (p_rd[i] == d_rs1 || p_rd[i] == d_rs2)) raw = 1;
      prt = d_we && d_rd != 0 && d_op != 3 && p_valid[NMUL-3] && p_rd[NMUL-3] != 0;
      ord = d_we && d_rd != 0 && p_valid[0] && p_rd[0] == d_rd;
      return int'(d_valid && (lu || raw || prt || ord));
   endfunction

   task automatic mul_seq(input string tag, input int exp);
      int cnt = 0;
      for (int c = 0; c < 8; c++) begin
         step();
         if (!stall) break;
         cnt++;
         for (int i = NT - 1; i > 0; i--) begin
            p_valid[i] = p_valid[i-1];
            p_rd[i]    = p_rd[i-1];
         end
         p_valid[0] = 0;
         p_rd[0]    = 0;
      end
      chk(tag, cnt, exp);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rs;
      logic [31:0] r2;
      idle();
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset / idle state
      step();
      chk("R1 idle sel_a", sel_a, 2);
      chk("R2 idle sel_b", sel_b, 2);
      chk("R3 idle sel_st", sel_st, 0);
      chk("R10 idle stall", stall, 0);

      // R1 priority, then writeback only
      x_rs1 = 1; m_valid = 1; m_we = 1; m_rd = 1; w_valid = 1; w_we = 1; w_rd = 1;
      step(); chk("R1 mem over wb", sel_a, 0);
      m_we = 0;
      step(); chk("R1 wb when mem not writing", sel_a, 1);
      chk("R2 untouched by rs1 match", sel_b, 2);

      // R2 independent
      idle(); x_rs1 = 1; x_rs2 = 2; w_valid = 1; w_we = 1; w_rd = 2;
      m_valid = 1; m_we = 1; m_rd = 1;
      step(); chk("R2 wb on B", sel_b, 1); chk("R1 mem on A", sel_a, 0);

      // R3 store data path
      idle(); m_valid = 1; m_op = 2; m_rs2 = 3; w_valid = 1; w_we = 1; w_rd = 3;
      step(); chk("R3 store from wb", sel_st, 1);
      m_op = 0;
      step(); chk("R3 non-store ignored", sel_st, 0);
      m_op = 2; w_we = 0;
      step(); chk("R3 wb not writing", sel_st, 0);

      // R4 / R5 load-use
      idle(); d_valid = 1; x_valid = 1; x_op = 1; x_we = 1; x_rd = 1; d_rs1 = 1;
      step(); chk("R4 load-use rs1", stall, 1);
      d_rs1 = 2; d_rs2 = 1; d_op = 2;
      step(); chk("R5 store data exempt", stall, 0);
      d_op = 0;
      step(); chk("R5 alu rs2 stalls", stall, 1);
      x_op = 0;
      step(); chk("R4 non-load no stall", stall, 0);

      // R6 multiply read
      idle(); d_valid = 1; d_rs2 = 2; p_valid[2] = 1; p_rd[2] = 2;
      step(); chk("R6 raw in P2", stall, 1);
      p_valid = '0; p_valid[1] = 1; p_rd = '0; p_rd[1] = 2;
      step(); chk("R6 raw in P1", stall, 1);

      // R7 port clash
      idle(); d_valid = 1; d_we = 1; d_rd = 1; p_valid[1] = 1; p_rd[1] = 3;
      step(); chk("R7 alu vs P1", stall, 1);
      d_op = 3;
      step(); chk("R7 multiply exempt", stall, 0);

      // R8 ordering
      idle(); d_valid = 1; d_op = 3; d_we = 1; d_rd = 3; p_valid[0] = 1; p_rd[0] = 3;
      step(); chk("R8 same dest behind P0", stall, 1);
      d_rd = 2;
      step(); chk("R8 other dest", stall, 0);

      // R9 register zero and invalid writers
      idle(); x_rs1 = 0; m_valid = 1; m_we = 1; m_rd = 0;
      step(); chk("R9 zero source", sel_a, 2);
      idle(); d_valid = 1; x_valid = 1; x_op = 1; x_we = 1; x_rd = 0;
      p_valid = '1; p_rd = '0; d_we = 1; d_rd = 1;
      step(); chk("R9 zero dests no stall", stall, 0);
      idle(); x_rs2 = 2; w_valid = 0; w_we = 1; w_rd = 2;
      step(); chk("R9 invalid wb", sel_b, 2);

      // R10 gating and independence
      idle(); x_valid = 1; x_op = 1; x_we = 1; x_rd = 1; d_rs1 = 1;
      step(); chk("R10 no decode no stall", stall, 0);
      d_valid = 1; x_rs1 = 1; m_valid = 1; m_we = 1; m_rd = 1;
      step(); chk("R10 stall raised", stall, 1); chk("R10 select under stall", sel_a, 0);

      // R11 multiply sequences
      idle(); d_valid = 1; d_rs1 = 3; d_we = 1; d_rd = 1; p_valid[0] = 1; p_rd[0] = 3;
      mul_seq("R11 dependent waits", 3);
      idle(); d_valid = 1; d_we = 1; d_rd = 3; p_valid[0] = 1; p_rd[0] = 3;
      mul_seq("R11 same dest waits", 2);

      // pseudo-random sweep against the reference
      rs = 32'h1234_5678;
      for (int k = 0; k < 3000; k++) begin
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
         r2 = rs * 32'h9E37_79B9;
         {d_valid, d_op, d_rs1, d_rs2, d_rd, d_we, x_valid, x_op, x_rs1, x_rs2, x_rd, x_we} = rs[21:0];
         {m_valid, m_op, m_rs2, m_rd, m_we, w_valid, w_rd, w_we} = r2[13:0];
         p_valid = r2[16:14];
         p_rd    = r2[22:17];
         if (r2[31:30] == 0) begin
            x_op = 1;
            d_valid = 1;
         end
         step();
         chk("R1 sweep", sel_a, want_sel(x_rs1));
         chk("R2 sweep", sel_b, want_sel(x_rs2));
         chk("R3 sweep", sel_st, want_st());
         chk("R10 sweep", stall, want_stall());
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule